// File: doc/BRIEF.md
# Preemptible Queue Mask Mapper

This block turns a bitmap of preemptible traffic classes into a bitmap of preemptible transmit queues. Each traffic class owns a contiguous range of queues, described by a first-queue offset and a queue count. Every class whose bit is set contributes all of its queues to the result. While it walks the classes, the block also checks whether the scheduler setup allows one class to feed several queues. A strict-priority scheduler never allows this. A weighted scheduler allows it only when every queue in the group carries the same weight.

A one-cycle start pulse captures the whole configuration and the current value of a queue-control register. The block then steps through the classes one per clock, and through the extra queues of a grouped class one per clock. It ends with a one-cycle done pulse. On success, done carries a register write whose bits 15:8 hold the queue mask and whose other bits are the captured value unchanged. On failure, done carries an error code and the index of the class at fault, and no write is issued.

Top module: `pq_mask_mapper`

## Requirements
- R1: When the walk succeeds, queue bit q of the mask is 1 exactly when some set class below the class count has offset <= q < offset+count.
- R2: A class with a count of 0 or 1 passes without any strict-priority or weight check. A count of 0 contributes no queue.
- R3: A class with a count above 1 fails with error code 2 when the strict-priority input is 1, whether or not its class bit is set. err_class gives that class.
- R4: A class with a count above 1 fails with error code 3 when any queue in its range has a weight different from the weight of its first queue. err_class gives that class.
- R5: An all-zero class bitmap skips every check, succeeds with a zero mask, and is done after a single walk cycle.
- R6: On success, reg_we is 1 in the done cycle, and reg_out equals the reg_in captured at start with bits 15:8 replaced by the mask. On error, reg_we stays 0.
- R7: A class whose offset+count exceeds the queue count (8) fails with error code 1. err_class gives that class.
- R8: Classes at or above num_classes are not examined. A num_classes value above 8 acts as 8.
- R9: busy rises in the cycle after start. A successful walk keeps busy high for 1 + the sum over examined classes of max(count,1) cycles. done is a one-cycle pulse in the first cycle with busy low.
- R10: Start pulses while busy are ignored. All inputs are captured at the accepted start, and later input changes do not affect the result.
- R11: Classes are examined in ascending order, and the first failing class is reported. Within a class, the range check comes before the strict-priority check, which comes before the weight check. Error code 0 means no error.
- R12: After reset, busy, done, err and reg_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| class_bits | input | 8 | Preemptible bitmap, one bit per class |
| num_classes | input | 4 | Number of classes in use |
| range_off | input | 24 | First queue per class, 3 bits per class, class 0 in the low bits |
| range_cnt | input | 32 | Queue count per class, 4 bits per class, class 0 in the low bits |
| strict_prio | input | 1 | Scheduler is strict priority |
| queue_weight | input | 64 | Weight per queue, 8 bits per queue, queue 0 in the low bits |
| reg_in | input | 32 | Current queue-control register value |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Walk failed (valid with done) |
| err_code | output | 2 | 0 none, 1 range overrun, 2 strict priority, 3 weight mismatch |
| err_class | output | 3 | Failing class index (valid with done and err) |
| reg_we | output | 1 | Register write strobe |
| reg_out | output | 32 | Register value to write |

## Verification
The bench sweeps every class bitmap over a one-to-one mapping and over a paired mapping. It then runs a broad pseudo-random sweep of offsets, counts, weights and class counts against an arithmetic model. Among the corner cases it targets: a weight mismatch on the last queue of a group, which a loop off by one would miss; a class that is unset but still misconfigured, which a design checking only set classes would pass; and a range ending exactly at queue 7 against one overrunning it. It also covers an all-zero bitmap over a configuration that is otherwise illegal, which a design without the early exit would reject. A second start in the middle of a walk would restart or corrupt the result in a design that does not lock out its inputs. A clamp missing from the class count would read beyond the table.

// File: rtl/pqm_pkg.sv
package pqm_pkg;
  typedef enum logic [1:0] {
    PQ_IDLE  = 2'd0,
    PQ_CLASS = 2'd1,
    PQ_QUEUE = 2'd2
  } pq_state_e;

  typedef enum logic [1:0] {
    PQ_OK     = 2'd0,
    PQ_RANGE  = 2'd1,
    PQ_STRICT = 2'd2,
    PQ_WEIGHT = 2'd3
  } pq_err_e;
endpackage

// File: rtl/pqm_range_mask.sv
module pqm_range_mask #(
  parameter int N_QUEUE = 8,
  localparam int OFF_W = $clog2(N_QUEUE),
  localparam int CNT_W = $clog2(N_QUEUE + 1)
) (
  input  logic [OFF_W-1:0]   off,
  input  logic [CNT_W-1:0]   cnt,
  output logic [N_QUEUE-1:0] qmask,
  output logic               overrun
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] lim;
  assign lim     = SUM_W'(off) + SUM_W'(cnt);
  assign overrun = lim > SUM_W'(N_QUEUE);

  for (genvar q = 0; q < N_QUEUE; q++) begin : g_bit
    assign qmask[q] = (SUM_W'(q) >= SUM_W'(off)) && (SUM_W'(q) < lim);
  end
endmodule

// File: rtl/pqm_weight_pick.sv
module pqm_weight_pick #(
  parameter int N_QUEUE = 8,
  parameter int W_W     = 8,
  localparam int IDX_W  = $clog2(N_QUEUE)
) (
  input  logic [N_QUEUE*W_W-1:0] weights,
  input  logic [IDX_W-1:0]       idx,
  output logic [W_W-1:0]         w
);
  logic [W_W-1:0] tbl [N_QUEUE];

  for (genvar i = 0; i < N_QUEUE; i++) begin : g_tbl
    assign tbl[i] = weights[i*W_W +: W_W];
  end

  assign w = tbl[idx];
endmodule

// File: rtl/pqm_walker.sv
module pqm_walker
  import pqm_pkg::*;
#(
  parameter int N_CLASS = 8,
  parameter int N_QUEUE = 8,
  parameter int W_W     = 8,
  localparam int OFF_W  = $clog2(N_QUEUE),
  localparam int CNT_W  = $clog2(N_QUEUE + 1),
  localparam int NC_W   = $clog2(N_CLASS + 1),
  localparam int CI_W   = $clog2(N_CLASS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [N_CLASS-1:0]       cls_bits,
  input  logic [NC_W-1:0]          n_cls,
  input  logic [N_CLASS*OFF_W-1:0] offs,
  input  logic [N_CLASS*CNT_W-1:0] cnts,
  input  logic                     strict,
  input  logic [N_QUEUE*W_W-1:0]   weights,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic [1:0]               err_code,
  output logic [CI_W-1:0]          err_class,
  output logic [N_QUEUE-1:0]       mask
);
  pq_state_e state;

  logic [N_CLASS-1:0]       bits_q;
  logic [NC_W-1:0]          ncls_q;
  logic [N_CLASS*OFF_W-1:0] off_q;
  logic [N_CLASS*CNT_W-1:0] cnt_q;
  logic                     strict_q;
  logic [N_QUEUE*W_W-1:0]   wts_q;
  logic [NC_W-1:0]          tc;
  logic [CNT_W-1:0]         qi;
  logic [W_W-1:0]           ref_w;
  logic [N_QUEUE-1:0]       acc;

  logic [OFF_W-1:0] off_a [N_CLASS];
  logic [CNT_W-1:0] cnt_a [N_CLASS];

  for (genvar gi = 0; gi < N_CLASS; gi++) begin : g_cfg
    assign off_a[gi] = off_q[gi*OFF_W +: OFF_W];
    assign cnt_a[gi] = cnt_q[gi*CNT_W +: CNT_W];
  end

  logic [CI_W-1:0]    cur_idx;
  logic [OFF_W-1:0]   cur_off;
  logic [CNT_W-1:0]   cur_cnt;
  logic [N_QUEUE-1:0] rmask;
  logic               overrun;
  logic [OFF_W-1:0]   pick_idx;
  logic [W_W-1:0]     pick_w;
  logic [NC_W-1:0]    n_cls_clamped;

  assign cur_idx  = tc[CI_W-1:0];
  assign cur_off  = off_a[cur_idx];
  assign cur_cnt  = cnt_a[cur_idx];
  assign pick_idx = cur_off + ((state == PQ_QUEUE) ? qi[OFF_W-1:0] : OFF_W'(0));
  assign n_cls_clamped = (n_cls > NC_W'(N_CLASS)) ? NC_W'(N_CLASS) : n_cls;

  pqm_range_mask #(.N_QUEUE(N_QUEUE)) u_range (
    .off     (cur_off),
    .cnt     (cur_cnt),
    .qmask   (rmask),
    .overrun (overrun)
  );

  pqm_weight_pick #(.N_QUEUE(N_QUEUE), .W_W(W_W)) u_pick (
    .weights (wts_q),
    .idx     (pick_idx),
    .w       (pick_w)
  );

  assign busy = (state != PQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PQ_IDLE;
      bits_q    <= '0;
      ncls_q    <= '0;
      off_q     <= '0;
      cnt_q     <= '0;
      strict_q  <= 1'b0;
      wts_q     <= '0;
      tc        <= '0;
      qi        <= '0;
      ref_w     <= '0;
      acc       <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= PQ_OK;
      err_class <= '0;
      mask      <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        PQ_IDLE: begin
          if (start) begin
            bits_q   <= cls_bits;
            ncls_q   <= n_cls_clamped;
            off_q    <= offs;
            cnt_q    <= cnts;
            strict_q <= strict;
            wts_q    <= weights;
            tc       <= '0;
            qi       <= '0;
            acc      <= '0;
            state    <= PQ_CLASS;
          end
        end
        PQ_CLASS: begin
          if (bits_q == '0 || tc == ncls_q) begin
            state     <= PQ_IDLE;
            done      <= 1'b1;
            err       <= 1'b0;
            err_code  <= PQ_OK;
            err_class <= '0;
            mask      <= acc;
          end else if (overrun) begin
            state     <= PQ_IDLE;
            done      <= 1'b1;
            err       <= 1'b1;
            err_code  <= PQ_RANGE;
            err_class <= cur_idx;
          end else begin
            if (bits_q[cur_idx]) acc <= acc | rmask;
            if (cur_cnt <= CNT_W'(1)) begin
              tc <= tc + NC_W'(1);
            end else if (strict_q) begin
              state     <= PQ_IDLE;
              done      <= 1'b1;
              err       <= 1'b1;
              err_code  <= PQ_STRICT;
              err_class <= cur_idx;
            end else begin
              ref_w <= pick_w;
              qi    <= CNT_W'(1);
              state <= PQ_QUEUE;
            end
          end
        end
        PQ_QUEUE: begin
          if (pick_w != ref_w) begin
            state     <= PQ_IDLE;
            done      <= 1'b1;
            err       <= 1'b1;
            err_code  <= PQ_WEIGHT;
            err_class <= cur_idx;
          end else if (qi == cur_cnt - CNT_W'(1)) begin
            tc    <= tc + NC_W'(1);
            state <= PQ_CLASS;
          end else begin
            qi <= qi + CNT_W'(1);
          end
        end
        default: state <= PQ_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_ends_walk_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_err_class_bound_R11: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (NC_W'(err_class) < ncls_q));

  assert_zero_map_R5: assert property (@(posedge clk) disable iff (rst)
    (done && bits_q == '0) |-> (!err && mask == '0));

  assert_acc_grows_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((acc & $past(acc)) == $past(acc)));

  assert_strict_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (done && err_code == PQ_STRICT) |-> strict_q);
endmodule

// File: rtl/pq_mask_mapper.sv
module pq_mask_mapper #(
  parameter int N_CLASS   = 8,
  parameter int N_QUEUE   = 8,
  parameter int W_W       = 8,
  parameter int REG_W     = 32,
  parameter int FIELD_LSB = 8,
  localparam int OFF_W    = $clog2(N_QUEUE),
  localparam int CNT_W    = $clog2(N_QUEUE + 1),
  localparam int NC_W     = $clog2(N_CLASS + 1),
  localparam int CI_W     = $clog2(N_CLASS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [N_CLASS-1:0]       class_bits,
  input  logic [NC_W-1:0]          num_classes,
  input  logic [N_CLASS*OFF_W-1:0] range_off,
  input  logic [N_CLASS*CNT_W-1:0] range_cnt,
  input  logic                     strict_prio,
  input  logic [N_QUEUE*W_W-1:0]   queue_weight,
  input  logic [REG_W-1:0]         reg_in,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic [1:0]               err_code,
  output logic [CI_W-1:0]          err_class,
  output logic                     reg_we,
  output logic [REG_W-1:0]         reg_out
);
  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'({N_QUEUE{1'b1}}) << FIELD_LSB;

  logic [REG_W-1:0]   hold_q;
  logic [N_QUEUE-1:0] qmask;

  pqm_walker #(.N_CLASS(N_CLASS), .N_QUEUE(N_QUEUE), .W_W(W_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cls_bits  (class_bits),
    .n_cls     (num_classes),
    .offs      (range_off),
    .cnts      (range_cnt),
    .strict    (strict_prio),
    .weights   (queue_weight),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .err_class (err_class),
    .mask      (qmask)
  );

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (start && !busy) hold_q <= reg_in;
  end

  assign reg_we  = done && !err;
  assign reg_out = (hold_q & ~FIELD_MASK) | (REG_W'(qmask) << FIELD_LSB);

  assert_we_needs_walk_R6: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(busy));
endmodule

// File: tb/tb_pq_mask_mapper.sv
module tb_pq_mask_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  class_bits = '0;
  logic [3:0]  num_classes = '0;
  logic [23:0] range_off = '0;
  logic [31:0] range_cnt = '0;
  logic        strict_prio = 1'b0;
  logic [63:0] queue_weight = '0;
  logic [31:0] reg_in = '0;
  logic        busy, done, err, reg_we;
  logic [1:0]  err_code;
  logic [2:0]  err_class;
  logic [31:0] reg_out;

  int n_chk = 0;
  int n_fail = 0;

  int c_off [8];
  int c_cnt [8];
  int q_w [8];
  int t_bits, t_n, t_strict;
  logic [31:0] t_reg;

  always #4 clk = ~clk;

  pq_mask_mapper dut (
    .clk(clk), .rst(rst), .start(start), .class_bits(class_bits),
    .num_classes(num_classes), .range_off(range_off), .range_cnt(range_cnt),
    .strict_prio(strict_prio), .queue_weight(queue_weight), .reg_in(reg_in),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .err_class(err_class), .reg_we(reg_we), .reg_out(reg_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Arithmetic model of the requirements
  task automatic model(output int e_code, output int e_cls, output int e_mask,
                       output int e_cyc);
    int n;
    e_code = 0; e_cls = 0; e_mask = 0; e_cyc = 1;
    if (t_bits == 0) return;
    n = (t_n > 8) ? 8 : t_n;
    for (int c = 0; c < n; c++) begin
      if (c_off[c] + c_cnt[c] > 8) begin e_code = 1; e_cls = c; return; end
      if (t_bits[c]) for (int q = c_off[c]; q < c_off[c] + c_cnt[c]; q++) e_mask |= (1 << q);
      if (c_cnt[c] <= 1) begin e_cyc += 1; continue; end
      if (t_strict != 0) begin e_code = 2; e_cls = c; return; end
      for (int q = 1; q < c_cnt[c]; q++)
        if (q_w[c_off[c] + q] != q_w[c_off[c]]) begin e_code = 3; e_cls = c; return; end
      e_cyc += c_cnt[c];
    end
  endtask

  task automatic run_case(input string tag, input bit disturb);
    int e_code, e_cls, e_mask, e_cyc, cyc, it;
    string req;
    model(e_code, e_cls, e_mask, e_cyc);
    req = (e_code == 1) ? "R7" : (e_code == 2) ? "R3" : (e_code == 3) ? "R4" : "R1";
    @(negedge clk);
    class_bits = t_bits[7:0];
    num_classes = t_n[3:0];
    strict_prio = t_strict[0];
    reg_in = t_reg;
    for (int c = 0; c < 8; c++) begin
      range_off[c*3 +: 3] = c_off[c][2:0];
      range_cnt[c*4 +: 4] = c_cnt[c][3:0];
      queue_weight[c*8 +: 8] = q_w[c][7:0];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", {tag, " busy after start"}, busy, 1);
    cyc = 1; it = 0;
    forever begin
      if (disturb && it == 0 && e_cyc >= 3) begin
        start = 1'b1; class_bits = ~class_bits; strict_prio = ~strict_prio;
        reg_in = ~reg_in; range_cnt = ~range_cnt; queue_weight = ~queue_weight;
      end
      @(negedge clk);
      start = 1'b0;
      it++;
      if (done === 1'b1) break;
      if (busy === 1'b1) cyc++;
      if (it > 100) break;
    end
    chk(done === 1'b1 && busy === 1'b0, "R9", {tag, " done with busy low"}, {done, busy}, 2);
    chk(err === (e_code != 0), req, {tag, " err"}, err, e_code != 0);
    chk(err_code == e_code[1:0], req, {tag, " code R11"}, err_code, e_code);
    if (e_code != 0) begin
      chk(err_class == e_cls[2:0], "R11", {tag, " class"}, err_class, e_cls);
      chk(reg_we === 1'b0, "R6", {tag, " no write on error"}, reg_we, 0);
    end else begin
      chk(reg_we === 1'b1, "R6", {tag, " write"}, reg_we, 1);
      chk(reg_out[15:8] == e_mask[7:0], "R1", {tag, " mask"}, reg_out[15:8], e_mask);
      chk(reg_out[31:16] == t_reg[31:16] && reg_out[7:0] == t_reg[7:0], "R6",
          {tag, " kept bits"}, reg_out, t_reg);
      chk(cyc == e_cyc, "R9", {tag, " busy cycles"}, cyc, e_cyc);
    end
    @(negedge clk);
    chk(done === 1'b0 && reg_we === 1'b0, "R9", {tag, " done pulse"}, {done, reg_we}, 0);
  endtask

  task automatic identity_cfg();
    for (int c = 0; c < 8; c++) begin c_off[c] = c; c_cnt[c] = 1; q_w[c] = c * 3 + 1; end
    t_n = 8; t_strict = 0; t_reg = 32'h1234_5678;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && reg_we === 0 && err === 0, "R12", "reset state",
        {busy, done, reg_we, err}, 0);
    rst = 1'b0;

    // R1 / R2: one-to-one mapping, strict scheduler, every bitmap
    identity_cfg(); t_strict = 1;
    for (int b = 0; b < 256; b++) begin t_bits = b; t_reg = b * 32'h0101_0101; run_case("R2 identity", 0); end

    // R1: pairs of queues, equal weights within a pair
    for (int c = 0; c < 8; c++) begin c_off[c] = (c < 4) ? 2 * c : 0; c_cnt[c] = (c < 4) ? 2 : 0; end
    for (int q = 0; q < 8; q++) q_w[q] = (q / 2) * 7 + 2;
    t_n = 4; t_strict = 0;
    for (int b = 0; b < 16; b++) begin t_bits = b; run_case("R1 pairs", 0); end
    t_n = 8; t_bits = 8'hF0; run_case("R2 zero-count classes", 0);

    // R3: strict priority with a group, also for an unset class
    t_strict = 1; t_bits = 8'h02; run_case("R3 strict pairs", 0);
    identity_cfg(); c_off[2] = 2; c_cnt[2] = 2; c_off[3] = 4; t_strict = 1; t_bits = 8'h01;
    run_case("R3 strict class2", 0);

    // R4: weight mismatch at every position of one full group
    for (int k = 1; k < 8; k++) begin
      for (int c = 0; c < 8; c++) begin c_off[c] = 0; c_cnt[c] = (c == 0) ? 8 : 1; end
      for (int q = 0; q < 8; q++) q_w[q] = 9;
      q_w[k] = 10; t_n = 1; t_strict = 0; t_bits = 8'h01;
      run_case("R4 mismatch", 0);
    end
    identity_cfg(); c_cnt[1] = 3; q_w[3] = 99; q_w[1] = 5; q_w[2] = 5; t_bits = 8'h01;
    run_case("R4 unset class", 0);

    // R7: range overrun and exact fit; R11 ordering
    identity_cfg(); c_off[3] = 6; c_cnt[3] = 3; t_bits = 8'hFF; run_case("R7 overrun", 0);
    identity_cfg(); c_off[7] = 7; c_cnt[7] = 1; c_off[6] = 5; c_cnt[6] = 2; q_w[6] = q_w[5];
    t_bits = 8'hC0; run_case("R7 exact fit", 0);
    identity_cfg(); c_cnt[0] = 2; q_w[1] = q_w[0]; c_off[1] = 7; c_cnt[1] = 2; t_strict = 1;
    t_bits = 8'h02; run_case("R11 first class wins", 0);
    identity_cfg(); c_off[2] = 6; c_cnt[2] = 4; t_strict = 1; t_bits = 8'h04;
    run_case("R11 range before strict", 0);

    // R5: zero bitmap over an illegal configuration
    identity_cfg(); c_off[0] = 7; c_cnt[0] = 5; c_cnt[1] = 3; t_strict = 1; t_bits = 0;
    t_reg = 32'hFFFF_FFFF; run_case("R5 zero bitmap", 0);

    // R8: class count limits
    identity_cfg(); c_off[2] = 7; c_cnt[2] = 4; t_n = 2; t_bits = 8'hFF; run_case("R8 n=2", 0);
    t_n = 0; run_case("R8 n=0", 0);
    identity_cfg(); t_n = 12; t_bits = 8'hA5; run_case("R8 n=12", 0);
    t_n = 15; t_bits = 8'h81; t_reg = 32'hA5A5_A5A5; run_case("R8 n=15", 0);

    // R10: start while busy ignored
    for (int c = 0; c < 8; c++) begin c_off[c] = (c < 2) ? 4 * c : 0; c_cnt[c] = (c < 2) ? 4 : 0; end
    for (int q = 0; q < 8; q++) q_w[q] = 3;
    t_n = 2; t_strict = 0; t_bits = 8'h02; t_reg = 32'h0F0F_0F0F;
    run_case("R10 disturb", 1);
    t_bits = 8'h03; run_case("R10 disturb both", 1);

    // Broad pseudo-random sweep
    for (int i = 0; i < 2500; i++) begin
      int nxt;
      nxt = 0;
      for (int c = 0; c < 8; c++) begin
        if ($urandom_range(0, 1) == 0) begin
          c_cnt[c] = $urandom_range(0, 3); c_off[c] = (nxt > 7) ? 7 : nxt; nxt += c_cnt[c];
        end else begin
          c_off[c] = $urandom_range(0, 7); c_cnt[c] = $urandom_range(0, 4);
        end
      end
      for (int q = 0; q < 8; q++) q_w[q] = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : 1;
      t_n = $urandom_range(0, 10);
      t_strict = ($urandom_range(0, 3) == 0) ? 1 : 0;
      t_bits = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(0, 255);
      t_reg = $urandom;
      run_case("sweep R1 R3 R4 R7 R11", (i % 17) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule